// File: doc/BRIEF.md
# Multi-Width Overlapping Register File

This block holds sixteen 64-bit general-purpose entries that can be read and written as 8-, 16-, 32- or 64-bit operands. Each access names a 4-bit register encoding, a 2-bit operand-size code and a one-bit extended-prefix flag. A single mode input selects between a 64-bit mode and a legacy mode. In legacy mode only the first eight entries are visible, at widths up to 32 bits. Byte accesses reach either bits 7:0 or bits 15:8 of an entry. The choice depends on the encoding and on the prefix flag.

There are two combinational read ports and one write port. A narrow write is merged into the stored value or zero-extends it, depending on its size. A read that targets the entry being written in the same cycle sees the merged result through a bypass path. An access that is illegal in the current mode has no effect: a write raises a one-cycle error pulse, and a read returns zero.

A companion 64-bit flags register sits beside the entries. Its upper half accepts any value but always reads back as zero.

Top module: `gpr_bank`

## Requirements
- R1: After reset every entry reads as zero at 64-bit width, the flags output is zero and `werr` is low.
- R2: Size codes are 0 = 8 bit, 1 = 16 bit, 2 = 32 bit and 3 = 64 bit. In 64-bit mode (`mode64` = 1), each of the sixteen entries can be written and read at 64-bit width. Encodings 8–15 are legal only with the prefix flag set.
- R3: For a byte access without the prefix flag, encodings 0–3 select bits 7:0 of entries 0–3, and encodings 4–7 select bits 15:8 of entries 0–3.
- R4: For a byte access with the prefix flag set, every encoding selects bits 7:0 of the entry with that number. Encodings 4–7 therefore reach entries 4–7, and bits 15:8 of entries 0–3 cannot be reached.
- R5: An 8-bit write changes only the selected byte of the entry. A 16-bit write changes only bits 15:0. All other bits keep their old value.
- R6: A 32-bit write stores bits 31:0 of the data and clears bits 63:32 of the entry.
- R7: A read returns the selected field right-aligned on its port, and all bits above the operand size are zero.
- R8: A write is illegal in these cases:
  - legacy mode with the prefix flag set;
  - legacy mode with encoding 8 or above;
  - legacy mode with size code 3;
  - 64-bit mode with encoding 8 or above and no prefix flag.
  An illegal write changes no entry, and `werr` is high for exactly the cycle after it. After a legal write or no write, `werr` is low.
- R9: A read that is illegal under the same rules as R8 returns zero.
- R10: When a read names the same entry as a legal write in the same cycle, the read returns the value the entry will hold after that write.
- R11: A flags write takes effect on the next clock edge. Bits 31:0 of `fl_rdata` return the written bits 31:0, and bits 63:32 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| we | input | 1 | Write enable |
| wa_idx | input | 4 | Write register encoding |
| wa_sz | input | 2 | Write size code |
| wa_ext | input | 1 | Write prefix flag |
| wa_data | input | 64 | Write data, right-aligned |
| werr | output | 1 | Illegal-write pulse, one cycle after the write |
| ra_idx | input | 4 | Read port A encoding |
| ra_sz | input | 2 | Read port A size code |
| ra_ext | input | 1 | Read port A prefix flag |
| ra_data | output | 64 | Read port A data, zero-extended |
| rb_idx | input | 4 | Read port B encoding |
| rb_sz | input | 2 | Read port B size code |
| rb_ext | input | 1 | Read port B prefix flag |
| rb_data | output | 64 | Read port B data, zero-extended |
| fl_we | input | 1 | Flags write enable |
| fl_wdata | input | 64 | Flags write data |
| fl_rdata | output | 64 | Flags read data, upper half zero |

## Verification
Read data is combinational, so the bench applies a read after a falling edge and samples it 1 time unit later, in the same cycle and before the next rising edge. That includes the bypass case, where the write is still pending.

A write becomes visible only after the next rising edge, and `werr` changes at that same edge. The bench therefore samples `werr` and any read-back at the following falling edge. The flags register follows the same one-edge timing.

All expected values come from a bench-side model of the entries that applies the mapping and merge rules of R3–R6 arithmetically.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    typedef enum logic [1:0] {
        OPSZ_8  = 2'd0,
        OPSZ_16 = 2'd1,
        OPSZ_32 = 2'd2,
        OPSZ_64 = 2'd3
    } opsz_e;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 16;
    localparam int DWORD_W = 32;

endpackage

// File: rtl/gpr_sel.sv
// Maps an encoding, size code, prefix flag and mode onto a physical entry,
// a high-byte select and a legality bit.
module gpr_sel
    import gpr_pkg::*;
#(
    parameter int NUM_REGS       = 16,
    parameter int LEGACY_REGS    = 8,
    parameter int HIGH_BYTE_BASE = 4,
    localparam int IDX_W         = $clog2(NUM_REGS)
) (
    input  logic             mode64,
    input  logic [IDX_W-1:0] idx,
    input  opsz_e            sz,
    input  logic             ext,
    output logic [IDX_W-1:0] entry,
    output logic             hi_byte,
    output logic             legal
);

    localparam int              HB_END = 2 * HIGH_BYTE_BASE;
    localparam logic [IDX_W-1:0] HB_OFS = IDX_W'(HIGH_BYTE_BASE);

    logic beyond_legacy;
    logic in_hb_window;

    always_comb begin
        beyond_legacy = int'(idx) >= LEGACY_REGS;
        in_hb_window  = (int'(idx) >= HIGH_BYTE_BASE) && (int'(idx) < HB_END);

        // Without the prefix, byte encodings in the window alias bits 15:8
        // of the entries one window lower.
        hi_byte = (sz == OPSZ_8) && !ext && in_hb_window;
        entry   = hi_byte ? (idx - HB_OFS) : idx;

        if (mode64) begin
            legal = !beyond_legacy || ext;
        end else begin
            legal = !ext && !beyond_legacy && (sz != OPSZ_64);
        end
    end

endmodule

// File: rtl/gpr_merge.sv
// Folds write data of a given size into the old contents of an entry.
module gpr_merge
    import gpr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wdata,
    input  opsz_e             sz,
    input  logic              hi_byte,
    output logic [DATA_W-1:0] merged
);

    always_comb begin
        merged = old_val;
        unique case (sz)
            OPSZ_8: begin
                if (hi_byte) begin
                    merged[2*BYTE_W-1:BYTE_W] = wdata[BYTE_W-1:0];
                end else begin
                    merged[BYTE_W-1:0] = wdata[BYTE_W-1:0];
                end
            end
            OPSZ_16: begin
                merged[WORD_W-1:0] = wdata[WORD_W-1:0];
            end
            OPSZ_32: begin
                merged                = '0;
                merged[DWORD_W-1:0]   = wdata[DWORD_W-1:0];
            end
            default: begin
                merged = wdata;
            end
        endcase
    end

endmodule

// File: rtl/gpr_extract.sv
// Selects and right-aligns the field a read asks for; zero when illegal.
module gpr_extract
    import gpr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] value,
    input  opsz_e             sz,
    input  logic              hi_byte,
    input  logic              legal,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (legal) begin
            unique case (sz)
                OPSZ_8: begin
                    rdata[BYTE_W-1:0] = hi_byte ? value[2*BYTE_W-1:BYTE_W]
                                                : value[BYTE_W-1:0];
                end
                OPSZ_16: rdata[WORD_W-1:0]  = value[WORD_W-1:0];
                OPSZ_32: rdata[DWORD_W-1:0] = value[DWORD_W-1:0];
                default: rdata              = value;
            endcase
        end
    end

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
#(
    parameter int NUM_REGS       = 16,
    parameter int LEGACY_REGS    = 8,
    parameter int HIGH_BYTE_BASE = 4,
    parameter int DATA_W         = 64,
    localparam int IDX_W         = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode64,
    input  logic              we,
    input  logic [IDX_W-1:0]  wa_idx,
    input  logic [1:0]        wa_sz,
    input  logic              wa_ext,
    input  logic [DATA_W-1:0] wa_data,
    output logic              werr,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [1:0]        ra_sz,
    input  logic              ra_ext,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [1:0]        rb_sz,
    input  logic              rb_ext,
    output logic [DATA_W-1:0] rb_data,
    input  logic              fl_we,
    input  logic [DATA_W-1:0] fl_wdata,
    output logic [DATA_W-1:0] fl_rdata
);

    localparam int N_RD    = 2;
    localparam int FL_LO_W = DWORD_W;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]               flags;
        logic                            werr;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // ---------------- write path ----------------
    logic [IDX_W-1:0]  wr_entry;
    logic              wr_hi;
    logic              wr_legal;
    logic [DATA_W-1:0] wr_merged;
    logic              wr_go;

    gpr_sel #(
        .NUM_REGS       (NUM_REGS),
        .LEGACY_REGS    (LEGACY_REGS),
        .HIGH_BYTE_BASE (HIGH_BYTE_BASE)
    ) i_wr_sel (
        .mode64  (mode64),
        .idx     (wa_idx),
        .sz      (opsz_e'(wa_sz)),
        .ext     (wa_ext),
        .entry   (wr_entry),
        .hi_byte (wr_hi),
        .legal   (wr_legal)
    );

    gpr_merge #(
        .DATA_W (DATA_W)
    ) i_wr_merge (
        .old_val (st_q.regs[wr_entry]),
        .wdata   (wa_data),
        .sz      (opsz_e'(wa_sz)),
        .hi_byte (wr_hi),
        .merged  (wr_merged)
    );

    assign wr_go = we && wr_legal;

    // ---------------- read paths ----------------
    logic [N_RD-1:0][IDX_W-1:0]  rd_idx;
    logic [N_RD-1:0][1:0]        rd_sz;
    logic [N_RD-1:0]             rd_ext;
    logic [N_RD-1:0][DATA_W-1:0] rd_out;

    assign rd_idx = {rb_idx, ra_idx};
    assign rd_sz  = {rb_sz, ra_sz};
    assign rd_ext = {rb_ext, ra_ext};

    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        logic [IDX_W-1:0]  rd_entry;
        logic              rd_hi;
        logic              rd_legal;
        logic [DATA_W-1:0] rd_src;

        gpr_sel #(
            .NUM_REGS       (NUM_REGS),
            .LEGACY_REGS    (LEGACY_REGS),
            .HIGH_BYTE_BASE (HIGH_BYTE_BASE)
        ) i_rd_sel (
            .mode64  (mode64),
            .idx     (rd_idx[g]),
            .sz      (opsz_e'(rd_sz[g])),
            .ext     (rd_ext[g]),
            .entry   (rd_entry),
            .hi_byte (rd_hi),
            .legal   (rd_legal)
        );

        // Same-cycle bypass of the pending write.
        assign rd_src = (wr_go && (wr_entry == rd_entry)) ? wr_merged
                                                          : st_q.regs[rd_entry];

        gpr_extract #(
            .DATA_W (DATA_W)
        ) i_rd_ext (
            .value   (rd_src),
            .sz      (opsz_e'(rd_sz[g])),
            .hi_byte (rd_hi),
            .legal   (rd_legal),
            .rdata   (rd_out[g])
        );
    end

    assign ra_data = rd_out[0];
    assign rb_data = rd_out[1];

    // ---------------- next state ----------------
    always_comb begin
        st_d      = st_q;
        st_d.werr = we && !wr_legal;
        if (wr_go) begin
            st_d.regs[wr_entry] = wr_merged;
        end
        if (fl_we) begin
            st_d.flags = fl_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign werr     = st_q.werr;
    assign fl_rdata = DATA_W'(st_q.flags[FL_LO_W-1:0]);

endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mode64,
    input logic        we,
    input logic [3:0]  wa_idx,
    input logic        wa_ext,
    input logic        werr,
    input logic [3:0]  ra_idx,
    input logic [1:0]  ra_sz,
    input logic [63:0] ra_data,
    input logic [63:0] fl_rdata
);

    // R8
    legacy_high_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !mode64 && wa_idx[3]) |=> werr);

    // R8
    long_high_noprefix_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && mode64 && wa_idx[3] && !wa_ext) |=> werr);

    // R8
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> !werr);

    // R11
    flags_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rdata[63:32] == 32'd0);

    // R7
    byte_read_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_sz == 2'd0) |-> (ra_data[63:8] == 56'd0));

    // R7
    dword_read_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_sz == 2'd2) |-> (ra_data[63:32] == 32'd0));

    // R9
    legacy_high_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode64 && ra_idx[3]) |-> (ra_data == 64'd0));

endmodule

bind gpr_bank gpr_bank_chk i_gpr_bank_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode64   (mode64),
    .we       (we),
    .wa_idx   (wa_idx),
    .wa_ext   (wa_ext),
    .werr     (werr),
    .ra_idx   (ra_idx),
    .ra_sz    (ra_sz),
    .ra_data  (ra_data),
    .fl_rdata (fl_rdata)
);

// File: tb/test_gpr_bank.sv
module test_gpr_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode64 = 1'b1;
    logic        we = 1'b0;
    logic [3:0]  wa_idx = '0;
    logic [1:0]  wa_sz = '0;
    logic        wa_ext = 1'b0;
    logic [63:0] wa_data = '0;
    logic        werr;
    logic [3:0]  ra_idx = '0;
    logic [1:0]  ra_sz = '0;
    logic        ra_ext = 1'b0;
    logic [63:0] ra_data;
    logic [3:0]  rb_idx = '0;
    logic [1:0]  rb_sz = 2'd3;
    logic        rb_ext = 1'b1;
    logic [63:0] rb_data;
    logic        fl_we = 1'b0;
    logic [63:0] fl_wdata = '0;
    logic [63:0] fl_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] mdl [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    gpr_bank i_gpr_bank (
        .clk(clk), .rst_n(rst_n), .mode64(mode64),
        .we(we), .wa_idx(wa_idx), .wa_sz(wa_sz), .wa_ext(wa_ext), .wa_data(wa_data),
        .werr(werr),
        .ra_idx(ra_idx), .ra_sz(ra_sz), .ra_ext(ra_ext), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_sz(rb_sz), .rb_ext(rb_ext), .rb_data(rb_data),
        .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
    );

    // {legal, hi, entry[3:0]} from the requirement rules
    function automatic logic [5:0] emap(input logic m, input logic [3:0] i,
                                        input logic [1:0] s, input logic e);
        logic lg, hi;
        logic [3:0] ent;
        lg  = m ? (!i[3] || e) : (!e && !i[3] && s != 2'd3);
        hi  = (s == 2'd0) && !e && (i >= 4) && (i <= 7);
        ent = hi ? i - 4'd4 : i;
        return {lg, hi, ent};
    endfunction

    function automatic logic [63:0] emerge(input logic [63:0] old, input logic [63:0] d,
                                           input logic [1:0] s, input logic hi);
        case (s)
            2'd0:    return hi ? ((old & ~64'hFF00) | ({56'd0, d[7:0]} << 8))
                               : ((old & ~64'hFF) | {56'd0, d[7:0]});
            2'd1:    return (old & ~64'hFFFF) | {48'd0, d[15:0]};
            2'd2:    return {32'd0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic [63:0] eext(input logic [63:0] v, input logic [1:0] s,
                                         input logic hi);
        case (s)
            2'd0:    return hi ? {56'd0, v[15:8]} : {56'd0, v[7:0]};
            2'd1:    return {48'd0, v[15:0]};
            2'd2:    return {32'd0, v[31:0]};
            default: return v;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input string tag, input logic [3:0] i, input logic [1:0] s,
                         input logic e, input logic [63:0] d);
        logic [5:0] mp;
        @(negedge clk);
        we = 1'b1; wa_idx = i; wa_sz = s; wa_ext = e; wa_data = d;
        mp = emap(mode64, i, s, e);
        @(posedge clk);
        if (mp[5]) mdl[mp[3:0]] = emerge(mdl[mp[3:0]], d, s, mp[4]);
        @(negedge clk);
        we = 1'b0;
        chk({tag, " werr"}, {63'd0, werr}, {63'd0, !mp[5]});
    endtask

    task automatic rd_a(input string tag, input logic [3:0] i, input logic [1:0] s,
                        input logic e);
        logic [5:0] mp;
        @(negedge clk);
        ra_idx = i; ra_sz = s; ra_ext = e;
        #1;
        mp = emap(mode64, i, s, e);
        chk(tag, ra_data, mp[5] ? eext(mdl[mp[3:0]], s, mp[4]) : 64'd0);
    endtask

    task automatic rd_full(input string tag, input int n);
        @(negedge clk);
        rb_idx = 4'(n); rb_sz = 2'd3; rb_ext = 1'b1;
        #1;
        chk(tag, rb_data, mdl[n]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 16; n++) mdl[n] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int n = 0; n < 16; n++) rd_full("R1 entry after reset", n);
        chk("R1 flags after reset", fl_rdata, 64'd0);
        chk("R1 werr after reset", {63'd0, werr}, 64'd0);

        // R2 full-width writes on every entry
        for (int n = 0; n < 16; n++)
            do_wr("R2 write64", 4'(n), 2'd3, 1'b1,
                  64'h0F1E_2D3C_4B5A_6978 * 64'(n + 3) + 64'(n));
        for (int n = 0; n < 16; n++) rd_full("R2 read64", n);

        // R3 / R4 / R5 byte writes, each encoding with and without prefix
        for (int e = 0; e < 2; e++)
            for (int i = 0; i < 16; i++) begin
                do_wr(e ? "R4 byte write prefix" : "R3 byte write", 4'(i), 2'd0,
                      1'(e), 64'(8'hA0 + i + 16 * e));
                rd_a(e ? "R4 byte read prefix" : "R3 byte read", 4'(i), 2'd0, 1'(e));
            end
        for (int n = 0; n < 16; n++) rd_full("R5 entry after byte writes", n);

        // R5 word writes keep upper bits
        for (int n = 0; n < 16; n++) begin
            do_wr("R5 write16", 4'(n), 2'd1, 1'b1, 64'hFFFF_FFFF_FFFF_0000 | 64'(n * 4099));
            rd_full("R5 entry after write16", n);
        end

        // R6 dword writes zero-extend
        for (int n = 0; n < 16; n += 3) begin
            do_wr("R6 write32", 4'(n), 2'd2, 1'b1, 64'hDEAD_BEEF_8765_4321 ^ 64'(n));
            rd_full("R6 entry after write32", n);
        end

        // R7 every size of every encoding with prefix, then without
        for (int e = 0; e < 2; e++)
            for (int i = 0; i < 16; i++)
                for (int s = 0; s < 4; s++)
                    rd_a("R7 aligned read", 4'(i), 2'(s), 1'(e));

        // R8 illegal writes leave every entry alone
        mode64 = 1'b0;
        do_wr("R8 legacy high entry", 4'd9, 2'd1, 1'b0, 64'h1111);
        do_wr("R8 legacy prefix", 4'd2, 2'd0, 1'b1, 64'h22);
        do_wr("R8 legacy size64", 4'd1, 2'd3, 1'b0, 64'h3333_3333_3333_3333);
        do_wr("R8 legacy legal write32", 4'd5, 2'd2, 1'b0, 64'h9999_4444_5555_6666);
        mode64 = 1'b1;
        do_wr("R8 long mode no prefix high", 4'd12, 2'd3, 1'b0, 64'h7777);
        do_wr("R8 legal after illegal", 4'd3, 2'd1, 1'b0, 64'hBEEF);
        for (int n = 0; n < 16; n++) rd_full("R8 entry after illegal writes", n);

        // R9 illegal reads return zero
        mode64 = 1'b0;
        rd_a("R9 legacy high read", 4'd10, 2'd1, 1'b0);
        rd_a("R9 legacy size64 read", 4'd2, 2'd3, 1'b0);
        rd_a("R3 legacy high byte read", 4'd6, 2'd0, 1'b0);
        mode64 = 1'b1;
        rd_a("R9 long mode no prefix high", 4'd13, 2'd2, 1'b0);

        // R10 same-cycle bypass
        for (int k = 0; k < 4; k++) begin
            logic [5:0] mp;
            logic [63:0] dv;
            dv = 64'h55AA_33CC_0F0F_F0F0 + 64'(k * 97);
            @(negedge clk);
            we = 1'b1; wa_idx = 4'(4 + k); wa_sz = 2'(k); wa_ext = 1'b0; wa_data = dv;
            mp = emap(1'b1, 4'(4 + k), 2'(k), 1'b0);
            ra_idx = mp[3:0]; ra_sz = 2'd3; ra_ext = 1'b1;
            #1;
            chk("R10 bypass read", ra_data, emerge(mdl[mp[3:0]], dv, 2'(k), mp[4]));
            @(posedge clk);
            mdl[mp[3:0]] = emerge(mdl[mp[3:0]], dv, 2'(k), mp[4]);
            @(negedge clk);
            we = 1'b0;
        end
        for (int n = 0; n < 8; n++) rd_full("R10 entry after bypass", n);

        // R11 flags upper half reads zero
        @(negedge clk);
        fl_we = 1'b1; fl_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        fl_we = 1'b0;
        chk("R11 flags all ones", fl_rdata, 64'h0000_0000_FFFF_FFFF);
        @(negedge clk);
        fl_we = 1'b1; fl_wdata = 64'h1234_5678_0000_0A5A;
        @(negedge clk);
        fl_we = 1'b0;
        chk("R11 flags pattern", fl_rdata, 64'h0000_0000_0000_0A5A);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule